// File: doc/BRIEF.md
# SDRAM Command Monitor

This block snoops the control pins of a synchronous DRAM bus and turns every clock into one decoded command. It keeps an open or closed flag for each bank, follows the progress of the current read or write burst, and tracks whether the device is running normally, powered down, clock-suspended or self-refreshing. Each illegal sequence produces a one-cycle error pulse with a reason code. The block stores no data and checks no analogue timing.

The block is used as a protocol checker in a testbench, or as a passive snoop block next to a memory controller. Every output is registered. The result for the pins sampled at one rising edge appears after that edge and holds until the next edge. The clock-enable level from the previous cycle selects how the current cycle is decoded. The burst length is copied from the mode-register opcode so that full-page bursts can be recognised.

Top module: `sdr_cmd_monitor`

## Requirements
- R1: With clock enable high in both the previous and the current cycle, pins {cs_n,ras_n,cas_n,we_n} decode as follows: 0111 no-op (code 1), 0011 activate (2), 0101 read (3, or 4 when a10 is high), 0100 write (5, or 6 when a10 is high), 0010 precharge (7, or 8 for all banks when a10 is high), 0000 mode set (9), 0001 refresh (10), 0110 burst stop (11). Any pattern with cs_n high decodes as deselect (0). The code appears on cmd_o after the sampling edge.
- R2: Activate opens the selected bank. Activate on a bank that is already open raises error code 2 and changes no bank.
- R3: Precharge with a10 low closes only the selected bank. With a10 high it closes every bank. Precharging an idle bank is legal. A precharge that closes the bank of the current burst also ends that burst.
- R4: Read or write to an idle bank raises error code 1 and starts no burst.
- R5: A mode set copies bl_field_i (opcode bits 2:0; 0,1,2,3 give 1,2,4,8 beats, 7 gives full page, other values give 1 beat) only when all banks are idle. Mode set or refresh with any bank open raises error code 3, and the mode set is then not stored.
- R6: A read or write with a10 high closes its bank at the edge BL-1 clocks after the edge that samples the command. For BL=1 that is the same edge. burst_o stays high until that edge.
- R7: In full-page mode a10 is ignored. The burst, shown on burst_o, lasts until a burst stop, a new read or write, or a precharge of its bank, and the bank stays open.
- R8: Burst stop while no burst is running raises error code 4. While a burst is running it ends the burst.
- R9: A falling clock enable enters clock-suspend (mode 2) while a burst runs. With no burst and pins 0001 it enters self-refresh (mode 3) if all banks are idle, or raises error code 3 and enters power-down if any bank is open. In every other case it enters power-down (mode 1). The burst count does not advance unless clock enable is high in both cycles.
- R10: A rising clock enable decodes as exit (code 15) and returns to normal mode (0). Cycles with clock enable low in both samples decode as hold (16). Pins in exit and hold cycles are ignored.
- R11: Every illegal command gives err_o high for the result cycle with its reason code, and opens no bank.
- R12: A read or write that interrupts a burst with a pending auto-precharge closes the old bank at once if it targets another bank. If it targets the same bank, the pending precharge is dropped.
- R13: During reset all outputs are zero: deselect, no error, normal mode, all banks idle, no burst.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Bus clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cke_i | input | 1 | Clock enable level |
| cs_ni | input | 1 | Chip select, active low |
| ras_ni | input | 1 | Row strobe, active low |
| cas_ni | input | 1 | Column strobe, active low |
| we_ni | input | 1 | Write enable, active low |
| ba_i | input | BA_W | Bank select |
| a10_i | input | 1 | Auto-precharge / all-banks flag |
| bl_field_i | input | BL_FIELD_W | Burst-length field of the mode opcode (address bits 2:0) |
| cmd_o | output | 5 | Decoded command code |
| err_o | output | 1 | Illegal-command pulse |
| err_code_o | output | 3 | Error reason (0 none, 1 idle bank, 2 open bank, 3 banks open, 4 no burst) |
| mode_o | output | 2 | Device mode (0 normal, 1 power-down, 2 clock-suspend, 3 self-refresh) |
| bank_active_o | output | NUM_BANKS | Per-bank open flag |
| burst_o | output | 1 | Burst in progress |

## Verification
The bench builds the block with NUM_BANKS=4 and a three-bit burst field. This lets precharge-all clear several open banks together and lets an interrupting read move between bank 0 and bank 3. Programming burst codes 2 and 7 covers both a counted four-beat burst and an open-ended full-page burst. The four-beat length is long enough to interrupt a burst partway through and to freeze it in clock-suspend before it completes.

// File: rtl/sdr_mon_pkg.sv
package sdr_mon_pkg;
  typedef enum logic [4:0] {
    CMD_DESEL   = 5'd0,
    CMD_NOP     = 5'd1,
    CMD_ACT     = 5'd2,
    CMD_RD      = 5'd3,
    CMD_RDA     = 5'd4,
    CMD_WR      = 5'd5,
    CMD_WRA     = 5'd6,
    CMD_PRE     = 5'd7,
    CMD_PREA    = 5'd8,
    CMD_MRS     = 5'd9,
    CMD_REF     = 5'd10,
    CMD_BST     = 5'd11,
    CMD_SREF_IN = 5'd12,
    CMD_PD_IN   = 5'd13,
    CMD_SUSP_IN = 5'd14,
    CMD_EXIT    = 5'd15,
    CMD_HOLD    = 5'd16
  } cmd_e;

  typedef enum logic [1:0] {
    MODE_NORMAL  = 2'd0,
    MODE_PDOWN   = 2'd1,
    MODE_SUSPEND = 2'd2,
    MODE_SREF    = 2'd3
  } mode_e;

  typedef enum logic [2:0] {
    ERR_NONE       = 3'd0,
    ERR_IDLE_BANK  = 3'd1,
    ERR_OPEN_BANK  = 3'd2,
    ERR_BANKS_OPEN = 3'd3,
    ERR_NO_BURST   = 3'd4
  } err_e;

  localparam int unsigned BL_FULL_CODE = 7;
  localparam int unsigned MAX_FIXED_BL = 8;
endpackage

// File: rtl/sdr_cmd_decode.sv
module sdr_cmd_decode
  import sdr_mon_pkg::*;
(
  input  logic cke_prev_i,
  input  logic cke_i,
  input  logic cs_ni,
  input  logic ras_ni,
  input  logic cas_ni,
  input  logic we_ni,
  input  logic a10_i,
  input  logic busy_i,
  output cmd_e cmd_o
);
  logic [2:0] pins;
  assign pins = {ras_ni, cas_ni, we_ni};

  always_comb begin
    cmd_o = CMD_HOLD;
    case ({cke_prev_i, cke_i})
      2'b00: cmd_o = CMD_HOLD;
      2'b01: cmd_o = CMD_EXIT;
      2'b10: begin
        // a running burst always turns a clock-enable fall into suspend
        if (busy_i)                        cmd_o = CMD_SUSP_IN;
        else if (!cs_ni && pins == 3'b001) cmd_o = CMD_SREF_IN;
        else                               cmd_o = CMD_PD_IN;
      end
      default: begin
        if (cs_ni) cmd_o = CMD_DESEL;
        else begin
          case (pins)
            3'b111:  cmd_o = CMD_NOP;
            3'b011:  cmd_o = CMD_ACT;
            3'b101:  cmd_o = a10_i ? CMD_RDA : CMD_RD;
            3'b100:  cmd_o = a10_i ? CMD_WRA : CMD_WR;
            3'b010:  cmd_o = a10_i ? CMD_PREA : CMD_PRE;
            3'b000:  cmd_o = CMD_MRS;
            3'b001:  cmd_o = CMD_REF;
            default: cmd_o = CMD_BST;
          endcase
        end
      end
    endcase
  end
endmodule

// File: rtl/sdr_bank_table.sv
module sdr_bank_table #(
  parameter int unsigned NUM_BANKS = 4
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic [NUM_BANKS-1:0] open_i,
  input  logic [NUM_BANKS-1:0] close_i,
  output logic [NUM_BANKS-1:0] active_o
);
  for (genvar g = 0; g < NUM_BANKS; g++) begin : g_bank
    logic act_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)         act_q <= 1'b0;
      else if (open_i[g])  act_q <= 1'b1;
      else if (close_i[g]) act_q <= 1'b0;
    end
    assign active_o[g] = act_q;

    // R2: the legality stage never asks to open a bank that is open
    a_r2_open_only_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
      open_i[g] |-> !act_q);
  end
endmodule

// File: rtl/sdr_burst_track.sv
module sdr_burst_track #(
  parameter int unsigned NUM_BANKS = 4,
  parameter int unsigned BA_W      = 2,
  parameter int unsigned CNT_W     = 3
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 start_i,
  input  logic [BA_W-1:0]      start_ba_i,
  input  logic                 start_ap_i,
  input  logic                 full_i,
  input  logic [CNT_W-1:0]     len_m1_i,
  input  logic                 advance_i,
  input  logic                 stop_i,
  input  logic [NUM_BANKS-1:0] kill_i,
  output logic                 busy_o,
  output logic [NUM_BANKS-1:0] close_o
);
  logic [CNT_W-1:0] rem_q;
  logic             full_q, ap_q;
  logic [BA_W-1:0]  bank_q;
  logic             pend;

  assign busy_o = (rem_q != '0) || full_q;
  assign pend   = ap_q && (rem_q != '0);

  always_comb begin
    close_o = '0;
    if (start_i) begin
      if (pend && bank_q != start_ba_i) close_o[bank_q] = 1'b1;
      if (start_ap_i && !full_i && len_m1_i == '0) close_o[start_ba_i] = 1'b1;
    end else if (stop_i) begin
      if (pend) close_o[bank_q] = 1'b1;
    end else if (advance_i && pend && rem_q == CNT_W'(1)) begin
      close_o[bank_q] = 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rem_q  <= '0;
      full_q <= 1'b0;
      ap_q   <= 1'b0;
      bank_q <= '0;
    end else if (start_i) begin
      rem_q  <= full_i ? '0 : len_m1_i;
      full_q <= full_i;
      ap_q   <= start_ap_i && !full_i && (len_m1_i != '0);
      bank_q <= start_ba_i;
    end else if (stop_i || kill_i[bank_q]) begin
      rem_q  <= '0;
      full_q <= 1'b0;
      ap_q   <= 1'b0;
    end else if (advance_i && rem_q != '0) begin
      rem_q <= rem_q - 1'b1;
      if (rem_q == CNT_W'(1)) ap_q <= 1'b0;
    end
  end

  // R7: an open-ended burst carries no count and no auto-precharge
  a_r7_full_no_ap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    full_q |-> (rem_q == '0 && !ap_q));
endmodule

// File: rtl/sdr_cmd_monitor.sv
module sdr_cmd_monitor
  import sdr_mon_pkg::*;
#(
  parameter  int unsigned NUM_BANKS  = 4,
  parameter  int unsigned BL_FIELD_W = 3,
  localparam int unsigned BA_W       = $clog2(NUM_BANKS),
  localparam int unsigned CNT_W      = $clog2(MAX_FIXED_BL)
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  cke_i,
  input  logic                  cs_ni,
  input  logic                  ras_ni,
  input  logic                  cas_ni,
  input  logic                  we_ni,
  input  logic [BA_W-1:0]       ba_i,
  input  logic                  a10_i,
  input  logic [BL_FIELD_W-1:0] bl_field_i,
  output logic [4:0]            cmd_o,
  output logic                  err_o,
  output logic [2:0]            err_code_o,
  output logic [1:0]            mode_o,
  output logic [NUM_BANKS-1:0]  bank_active_o,
  output logic                  burst_o
);
  logic                  cke_q;
  cmd_e                  cmd_d, cmd_q;
  err_e                  err_d, err_q;
  mode_e                 mode_d, mode_q;
  logic                  busy;
  logic [NUM_BANKS-1:0]  active, open_req, pre_close, burst_close;
  logic                  start, stop, mrs_we, all_idle, tgt_active, start_ap;
  logic [BL_FIELD_W-1:0] bl_q;
  logic [CNT_W:0]        bl_pow;
  logic [CNT_W-1:0]      len_m1;
  logic                  full_pg;

  sdr_cmd_decode u_dec (
    .cke_prev_i (cke_q),
    .cke_i      (cke_i),
    .cs_ni      (cs_ni),
    .ras_ni     (ras_ni),
    .cas_ni     (cas_ni),
    .we_ni      (we_ni),
    .a10_i      (a10_i),
    .busy_i     (busy),
    .cmd_o      (cmd_d)
  );

  assign all_idle   = ~|active;
  assign tgt_active = active[ba_i];
  assign start_ap   = (cmd_d == CMD_RDA) || (cmd_d == CMD_WRA);
  assign full_pg    = (bl_q == BL_FIELD_W'(BL_FULL_CODE));
  assign bl_pow     = (CNT_W + 1)'(1) << bl_q;
  // reserved codes fall back to a single beat
  assign len_m1     = (bl_q <= BL_FIELD_W'(CNT_W)) ? bl_pow[CNT_W-1:0] - 1'b1 : '0;

  always_comb begin
    err_d     = ERR_NONE;
    open_req  = '0;
    pre_close = '0;
    start     = 1'b0;
    stop      = 1'b0;
    mrs_we    = 1'b0;
    mode_d    = mode_q;
    case (cmd_d)
      CMD_ACT: if (tgt_active) err_d = ERR_OPEN_BANK;
               else            open_req[ba_i] = 1'b1;
      CMD_RD, CMD_RDA, CMD_WR, CMD_WRA:
               if (!tgt_active) err_d = ERR_IDLE_BANK;
               else             start = 1'b1;
      CMD_PRE:  pre_close[ba_i] = 1'b1;
      CMD_PREA: pre_close = '1;
      CMD_MRS: if (!all_idle) err_d = ERR_BANKS_OPEN;
               else           mrs_we = 1'b1;
      CMD_REF: if (!all_idle) err_d = ERR_BANKS_OPEN;
      CMD_BST: if (!busy)     err_d = ERR_NO_BURST;
               else           stop = 1'b1;
      CMD_SREF_IN: begin
        if (!all_idle) begin
          err_d  = ERR_BANKS_OPEN;
          mode_d = MODE_PDOWN;
        end else begin
          mode_d = MODE_SREF;
        end
      end
      CMD_PD_IN:   mode_d = MODE_PDOWN;
      CMD_SUSP_IN: mode_d = MODE_SUSPEND;
      CMD_EXIT:    mode_d = MODE_NORMAL;
      default: ;
    endcase
  end

  sdr_burst_track #(
    .NUM_BANKS (NUM_BANKS),
    .BA_W      (BA_W),
    .CNT_W     (CNT_W)
  ) u_burst (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .start_i    (start),
    .start_ba_i (ba_i),
    .start_ap_i (start_ap),
    .full_i     (full_pg),
    .len_m1_i   (len_m1),
    .advance_i  (cke_q & cke_i),
    .stop_i     (stop),
    .kill_i     (pre_close),
    .busy_o     (busy),
    .close_o    (burst_close)
  );

  sdr_bank_table #(
    .NUM_BANKS (NUM_BANKS)
  ) u_banks (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .open_i   (open_req),
    .close_i  (pre_close | burst_close),
    .active_o (active)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cke_q  <= 1'b1;
      cmd_q  <= CMD_DESEL;
      err_q  <= ERR_NONE;
      mode_q <= MODE_NORMAL;
      bl_q   <= '0;
    end else begin
      cke_q  <= cke_i;
      cmd_q  <= cmd_d;
      err_q  <= err_d;
      mode_q <= mode_d;
      if (mrs_we) bl_q <= bl_field_i;
    end
  end

  assign cmd_o         = cmd_q;
  assign err_o         = (err_q != ERR_NONE);
  assign err_code_o    = err_q;
  assign mode_o        = mode_q;
  assign bank_active_o = active;
  assign burst_o       = busy;

  // R11: an illegal command never opens a bank
  a_r11_err_opens_none: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |-> ((bank_active_o & ~$past(bank_active_o)) == '0));
  // R9: self-refresh is only held with every bank closed
  a_r9_sref_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_o == MODE_SREF) |-> (bank_active_o == '0));
  // R9: a burst survives only in normal or clock-suspend mode
  a_r9_burst_mode: assert property (@(posedge clk_i) disable iff (!rst_ni)
    burst_o |-> (mode_o == MODE_NORMAL || mode_o == MODE_SUSPEND));
  // R10: normal mode implies clock enable was sampled high
  a_r10_normal_cke: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_o == MODE_NORMAL) |-> cke_q);
  // R5: an accepted mode set was issued with all banks idle
  a_r5_mrs_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_o == CMD_MRS && !err_o) |-> ($past(bank_active_o) == '0));
endmodule

// File: tb/sdr_cmd_monitor_test.sv
module sdr_cmd_monitor_test;
  import sdr_mon_pkg::*;

  localparam int CLK_PERIOD = 10;
  localparam logic [3:0] P_DES = 4'b1111, P_NOP = 4'b0111, P_ACT = 4'b0011,
                         P_RD  = 4'b0101, P_WR  = 4'b0100, P_PRE = 4'b0010,
                         P_MRS = 4'b0000, P_REF = 4'b0001, P_BST = 4'b0110;

  logic       clk = 1'b0, rst_ni = 1'b0;
  logic       cke = 1'b1, cs_n = 1'b0, ras_n = 1'b1, cas_n = 1'b1, we_n = 1'b1;
  logic [1:0] ba = '0;
  logic       a10 = 1'b0;
  logic [2:0] bl_field = '0;
  logic [4:0] cmd_o;
  logic       err_o, burst_o;
  logic [2:0] err_code_o;
  logic [1:0] mode_o;
  logic [3:0] bank_active_o;

  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;

  typedef struct {
    logic [4:0] cmd; logic [2:0] code; logic [1:0] mode;
    logic [3:0] banks; logic busy; string req;
  } exp_t;
  exp_t sb_q[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  sdr_cmd_monitor uut (
    .clk_i(clk), .rst_ni(rst_ni), .cke_i(cke), .cs_ni(cs_n), .ras_ni(ras_n),
    .cas_ni(cas_n), .we_ni(we_n), .ba_i(ba), .a10_i(a10), .bl_field_i(bl_field),
    .cmd_o(cmd_o), .err_o(err_o), .err_code_o(err_code_o), .mode_o(mode_o),
    .bank_active_o(bank_active_o), .burst_o(burst_o)
  );

  task automatic step(input logic [3:0] p, input logic k, input logic [1:0] b,
                      input logic a, input logic [2:0] bl, input cmd_e ec,
                      input err_e ee, input mode_e em, input logic [3:0] eb,
                      input logic ebusy, input string req);
    exp_t e;
    @(negedge clk); #1;
    {cs_n, ras_n, cas_n, we_n} = p;
    cke = k; ba = b; a10 = a; bl_field = bl;
    e.cmd = ec; e.code = ee; e.mode = em; e.banks = eb; e.busy = ebusy; e.req = req;
    sb_q.push_back(e);
  endtask

  // scoreboard monitor: one expected item per driven cycle
  always @(negedge clk) begin
    if (sb_q.size() > 0) begin
      exp_t e;
      e = sb_q.pop_front();
      n_chk++;
      if (cmd_o !== e.cmd || err_o !== (e.code != 3'd0) || err_code_o !== e.code ||
          mode_o !== e.mode || bank_active_o !== e.banks || burst_o !== e.busy) begin
        n_fail++;
        $display("FAIL %s: got cmd=%0d err=%0b code=%0d mode=%0d banks=%b burst=%0b exp cmd=%0d err=%0b code=%0d mode=%0d banks=%b burst=%0b",
                 e.req, cmd_o, err_o, err_code_o, mode_o, bank_active_o, burst_o,
                 e.cmd, (e.code != 3'd0), e.code, e.mode, e.banks, e.busy);
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: got hung run exp completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    n_chk++;  // R13 reset state
    if (cmd_o !== 5'd0 || err_o !== 1'b0 || err_code_o !== 3'd0 || mode_o !== 2'd0 ||
        bank_active_o !== 4'b0 || burst_o !== 1'b0) begin
      n_fail++;
      $display("FAIL R13: got cmd=%0d err=%0b mode=%0d banks=%b burst=%0b exp all zero",
               cmd_o, err_o, mode_o, bank_active_o, burst_o);
    end
    rst_ni = 1'b1;

    // R5 / R1 / R2 / R4 basic legality
    step(P_MRS, 1, 0, 0, 3'd2, CMD_MRS, ERR_NONE, MODE_NORMAL, 4'b0000, 0, "R5 mode set idle");
    step(P_DES, 1, 0, 0, 3'd0, CMD_DESEL, ERR_NONE, MODE_NORMAL, 4'b0000, 0, "R1 deselect");
    step(P_ACT, 1, 0, 0, 3'd0, CMD_ACT, ERR_NONE, MODE_NORMAL, 4'b0001, 0, "R2 activate");
    step(P_ACT, 1, 0, 0, 3'd0, CMD_ACT, ERR_OPEN_BANK, MODE_NORMAL, 4'b0001, 0, "R2 R11 double activate");
    step(P_RD, 1, 1, 0, 3'd0, CMD_RD, ERR_IDLE_BANK, MODE_NORMAL, 4'b0001, 0, "R4 read idle");
    step(P_WR, 1, 1, 0, 3'd0, CMD_WR, ERR_IDLE_BANK, MODE_NORMAL, 4'b0001, 0, "R4 write idle");
    step(P_MRS, 1, 0, 0, 3'd3, CMD_MRS, ERR_BANKS_OPEN, MODE_NORMAL, 4'b0001, 0, "R5 mode set open");
    step(P_REF, 1, 0, 0, 3'd0, CMD_REF, ERR_BANKS_OPEN, MODE_NORMAL, 4'b0001, 0, "R5 refresh open");
    step(P_ACT, 1, 1, 0, 3'd0, CMD_ACT, ERR_NONE, MODE_NORMAL, 4'b0011, 0, "R2 activate b1");
    // R6 BL4 auto-precharge (also proves rejected mode set left BL at 4)
    step(P_RD, 1, 0, 1, 3'd0, CMD_RDA, ERR_NONE, MODE_NORMAL, 4'b0011, 1, "R6 read ap");
    step(P_NOP, 1, 0, 0, 3'd0, CMD_NOP, ERR_NONE, MODE_NORMAL, 4'b0011, 1, "R6 beat");
    step(P_NOP, 1, 0, 0, 3'd0, CMD_NOP, ERR_NONE, MODE_NORMAL, 4'b0011, 1, "R6 beat");
    step(P_NOP, 1, 0, 0, 3'd0, CMD_NOP, ERR_NONE, MODE_NORMAL, 4'b0010, 0, "R6 ap close");
    // R8 burst stop
    step(P_BST, 1, 0, 0, 3'd0, CMD_BST, ERR_NO_BURST, MODE_NORMAL, 4'b0010, 0, "R8 stop idle");
    step(P_WR, 1, 1, 0, 3'd0, CMD_WR, ERR_NONE, MODE_NORMAL, 4'b0010, 1, "R1 write");
    step(P_BST, 1, 0, 0, 3'd0, CMD_BST, ERR_NONE, MODE_NORMAL, 4'b0010, 0, "R8 stop burst");
    // R9 / R10 power-down
    step(P_NOP, 0, 0, 0, 3'd0, CMD_PD_IN, ERR_NONE, MODE_PDOWN, 4'b0010, 0, "R9 power-down");
    step(P_ACT, 0, 0, 0, 3'd0, CMD_HOLD, ERR_NONE, MODE_PDOWN, 4'b0010, 0, "R10 hold ignored");
    step(P_NOP, 1, 0, 0, 3'd0, CMD_EXIT, ERR_NONE, MODE_NORMAL, 4'b0010, 0, "R10 exit");
    // R9 clock-suspend freezes burst
    step(P_WR, 1, 1, 0, 3'd0, CMD_WR, ERR_NONE, MODE_NORMAL, 4'b0010, 1, "R1 write");
    step(P_NOP, 0, 0, 0, 3'd0, CMD_SUSP_IN, ERR_NONE, MODE_SUSPEND, 4'b0010, 1, "R9 suspend");
    step(P_NOP, 0, 0, 0, 3'd0, CMD_HOLD, ERR_NONE, MODE_SUSPEND, 4'b0010, 1, "R10 hold");
    step(P_NOP, 1, 0, 0, 3'd0, CMD_EXIT, ERR_NONE, MODE_NORMAL, 4'b0010, 1, "R10 exit");
    step(P_NOP, 1, 0, 0, 3'd0, CMD_NOP, ERR_NONE, MODE_NORMAL, 4'b0010, 1, "R9 frozen");
    step(P_NOP, 1, 0, 0, 3'd0, CMD_NOP, ERR_NONE, MODE_NORMAL, 4'b0010, 1, "R9 frozen");
    step(P_NOP, 1, 0, 0, 3'd0, CMD_NOP, ERR_NONE, MODE_NORMAL, 4'b0010, 0, "R9 burst end");
    // R3 precharge
    step(P_PRE, 1, 0, 1, 3'd0, CMD_PREA, ERR_NONE, MODE_NORMAL, 4'b0000, 0, "R3 precharge all");
    step(P_PRE, 1, 2, 0, 3'd0, CMD_PRE, ERR_NONE, MODE_NORMAL, 4'b0000, 0, "R3 precharge idle");
    step(P_REF, 1, 0, 0, 3'd0, CMD_REF, ERR_NONE, MODE_NORMAL, 4'b0000, 0, "R5 refresh idle");
    // R9 self-refresh
    step(P_REF, 0, 0, 0, 3'd0, CMD_SREF_IN, ERR_NONE, MODE_SREF, 4'b0000, 0, "R9 self-refresh");
    step(P_NOP, 0, 0, 0, 3'd0, CMD_HOLD, ERR_NONE, MODE_SREF, 4'b0000, 0, "R10 hold");
    step(P_NOP, 1, 0, 0, 3'd0, CMD_EXIT, ERR_NONE, MODE_NORMAL, 4'b0000, 0, "R10 exit");
    step(P_ACT, 1, 1, 0, 3'd0, CMD_ACT, ERR_NONE, MODE_NORMAL, 4'b0010, 0, "R2 activate");
    step(P_REF, 0, 0, 0, 3'd0, CMD_SREF_IN, ERR_BANKS_OPEN, MODE_PDOWN, 4'b0010, 0, "R9 sref open");
    step(P_NOP, 1, 0, 0, 3'd0, CMD_EXIT, ERR_NONE, MODE_NORMAL, 4'b0010, 0, "R10 exit");
    step(P_PRE, 1, 0, 1, 3'd0, CMD_PREA, ERR_NONE, MODE_NORMAL, 4'b0000, 0, "R3 precharge all");
    // R7 full page
    step(P_MRS, 1, 0, 0, 3'd7, CMD_MRS, ERR_NONE, MODE_NORMAL, 4'b0000, 0, "R5 full page set");
    step(P_ACT, 1, 2, 0, 3'd0, CMD_ACT, ERR_NONE, MODE_NORMAL, 4'b0100, 0, "R2 activate b2");
    step(P_RD, 1, 2, 1, 3'd0, CMD_RDA, ERR_NONE, MODE_NORMAL, 4'b0100, 1, "R7 full read");
    for (int i = 0; i < 10; i++)
      step(P_NOP, 1, 0, 0, 3'd0, CMD_NOP, ERR_NONE, MODE_NORMAL, 4'b0100, 1, "R7 full runs");
    step(P_BST, 1, 0, 0, 3'd0, CMD_BST, ERR_NONE, MODE_NORMAL, 4'b0100, 0, "R7 stop keeps bank");
    step(P_PRE, 1, 0, 1, 3'd0, CMD_PREA, ERR_NONE, MODE_NORMAL, 4'b0000, 0, "R3 precharge all");
    // R12 interrupted bursts
    step(P_MRS, 1, 0, 0, 3'd2, CMD_MRS, ERR_NONE, MODE_NORMAL, 4'b0000, 0, "R5 bl4 set");
    step(P_ACT, 1, 0, 0, 3'd0, CMD_ACT, ERR_NONE, MODE_NORMAL, 4'b0001, 0, "R2 activate b0");
    step(P_ACT, 1, 3, 0, 3'd0, CMD_ACT, ERR_NONE, MODE_NORMAL, 4'b1001, 0, "R2 activate b3");
    step(P_RD, 1, 0, 1, 3'd0, CMD_RDA, ERR_NONE, MODE_NORMAL, 4'b1001, 1, "R6 read ap b0");
    step(P_NOP, 1, 0, 0, 3'd0, CMD_NOP, ERR_NONE, MODE_NORMAL, 4'b1001, 1, "R6 beat");
    step(P_RD, 1, 3, 0, 3'd0, CMD_RD, ERR_NONE, MODE_NORMAL, 4'b1000, 1, "R12 other bank closes");
    step(P_RD, 1, 3, 1, 3'd0, CMD_RDA, ERR_NONE, MODE_NORMAL, 4'b1000, 1, "R12 read ap b3");
    step(P_RD, 1, 3, 0, 3'd0, CMD_RD, ERR_NONE, MODE_NORMAL, 4'b1000, 1, "R12 same bank drop");
    step(P_NOP, 1, 0, 0, 3'd0, CMD_NOP, ERR_NONE, MODE_NORMAL, 4'b1000, 1, "R12 beat");
    step(P_NOP, 1, 0, 0, 3'd0, CMD_NOP, ERR_NONE, MODE_NORMAL, 4'b1000, 1, "R12 beat");
    step(P_NOP, 1, 0, 0, 3'd0, CMD_NOP, ERR_NONE, MODE_NORMAL, 4'b1000, 0, "R12 bank kept");
    step(P_RD, 1, 3, 0, 3'd0, CMD_RD, ERR_NONE, MODE_NORMAL, 4'b1000, 1, "R1 read b3");
    step(P_PRE, 1, 3, 0, 3'd0, CMD_PRE, ERR_NONE, MODE_NORMAL, 4'b0000, 0, "R3 precharge ends burst");

    repeat (3) @(negedge clk);
    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule